// File: doc/BRIEF.md
# Two-Cluster Stitched Store Forwarding

This block makes two cluster-local store-to-load forwarding buffers behave as one buffer for a single instruction window. The window spans an older cluster (index 0) and a younger cluster (index 1). Each cluster keeps its own store entries. An entry holds a valid bit, a program-order age, an address-known bit, a word address and a data word. Stores are written through three separate ports per cluster: allocate with age, address, and data. Each port addresses an entry by its slot number.

Each cluster has one load port that handles one load at a time. A load first searches its own cluster for address-known stores that are earlier in program order. It is held while any earlier store in reach still has an unknown address. The older cluster reports that it holds an unknown-address store through a one-bit summary flag, and a younger load is held while that flag is high. If a younger load misses locally, it sends one lookup to the older cluster. The older cluster answers the next cycle, using only stores whose addresses are resolved. If both clusters miss, the load is reported as going to memory. A load in the older cluster has nothing older than it, so it searches its own buffer only.

Top module: `stitched_stlf`

## Requirements
- R1: After reset, every load port reports ready, no response is valid, and the cross-cluster unknown flag and lookup valid are low.
- R2: `xc_unknown` is high exactly while the older cluster holds a valid store whose address is not yet known. Unknown-address stores in the younger cluster do not raise it.
- R3: A load is held while its own cluster holds a valid store with a smaller age and an unknown address. Once the last such address is written, the response is valid in the second cycle after the address write cycle. No response appears while the load is held.
- R4: A younger-cluster load is held, with no response and no lookup, while `xc_unknown` is high.
- R5: A local hit returns the data of the matching address-known store with the largest age below the load's age. It reports source code 0 (local) in the cycle after the first unblocked check, and no lookup leaves the cluster.
- R6: Stores with an age equal to or above the load's age are ignored, both for matching and for holding.
- R7: A younger load that misses locally raises `xc_lookup_vld` for one cycle with the load's address. The older cluster answers on the next cycle with its youngest matching address-known store. The load response then reports source code 1 (remote) with that data, three cycles after the unblocked check began.
- R8: A load that misses in every buffer it may search reports source code 2 (memory) with data zero.
- R9: An older-cluster load never issues a lookup. On a local miss it reports memory in the cycle after its first unblocked check.
- R10: Each load port holds one load at a time. Ready is low from acceptance until the response, and a request presented while ready is low is ignored. At most one lookup is outstanding.
- R11: Addresses match only when the full word address is equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_alloc_vld | input | 2 | Per cluster: allocate a store entry (clears its address-known bit) |
| st_alloc_slot | input | 2x3 | Per cluster: entry index to allocate |
| st_alloc_age | input | 2x8 | Per cluster: program-order age of the new store |
| st_addr_vld | input | 2 | Per cluster: write a resolved store address |
| st_addr_slot | input | 2x3 | Per cluster: entry index for the address write |
| st_addr | input | 2x30 | Per cluster: store word address |
| st_data_vld | input | 2 | Per cluster: write store data |
| st_data_slot | input | 2x3 | Per cluster: entry index for the data write |
| st_data | input | 2x32 | Per cluster: store data |
| ld_req_vld | input | 2 | Per cluster: load request |
| ld_req_age | input | 2x8 | Per cluster: load program-order age |
| ld_req_addr | input | 2x30 | Per cluster: load word address |
| ld_req_rdy | output | 2 | Per cluster: load port idle, request accepted |
| ld_rsp_vld | output | 2 | Per cluster: one-cycle load response |
| ld_rsp_src | output | 2x2 | Per cluster: 0 local, 1 remote, 2 memory |
| ld_rsp_data | output | 2x32 | Per cluster: forwarded data, zero for memory |
| xc_unknown | output | 1 | Older cluster holds an unknown-address store |
| xc_lookup_vld | output | 1 | Younger-to-older lookup valid |
| xc_lookup_addr | output | 30 | Lookup word address |
| xc_answer_vld | output | 1 | Older-cluster lookup answer valid |
| xc_answer_hit | output | 1 | Lookup answer found a match |

## Verification
Several store patterns drive the forwarding search. Several same-address stores of mixed age test youngest-earlier selection against first-found or oldest selection. Stores above the load's age test the age filter. Neighbouring word addresses separate full-address compare from partial compare. Holding is tested with an unknown store in each cluster, and the release cycle is pinned exactly. Lookup counts per scenario separate local hits, remote hits and memory misses from one another. A request made while the port is busy shows whether a second load is wrongly accepted.

// File: rtl/stlf_pkg.sv
// Shared widths and types for the stitched store-forwarding buffer.
// Assumes word addressing and a non-wrapping age field within a window.
package stlf_pkg;
    parameter int AGE_W  = 8;
    parameter int ADDR_W = 30;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic              vld;
        logic [AGE_W-1:0]  age;
        logic              avld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } st_entry_t;

    typedef enum logic [1:0] {
        SRC_LOCAL  = 2'd0,
        SRC_REMOTE = 2'd1,
        SRC_MEMORY = 2'd2
    } ld_src_t;
endpackage

// File: rtl/stlf_store_array.sv
// Per-cluster store entry storage with slot-addressed allocate, address
// and data write ports. Assumes the allocator hands out free slots; an
// address write in the same cycle as allocation of the same slot wins.
module stlf_store_array
    import stlf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_vld,
    input  logic [IDX_W-1:0]        alloc_slot,
    input  logic [AGE_W-1:0]        alloc_age,
    input  logic                    addr_vld,
    input  logic [IDX_W-1:0]        addr_slot,
    input  logic [ADDR_W-1:0]       addr_wr,
    input  logic                    data_vld,
    input  logic [IDX_W-1:0]        data_slot,
    input  logic [DATA_W-1:0]       data_wr,
    output st_entry_t [DEPTH-1:0]   ents
);

    st_entry_t [DEPTH-1:0] ents_q;

    // Entry update: allocate, then address and data writes per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_vld && alloc_slot == IDX_W'(i)) begin
                    ents_q[i].vld  <= 1'b1;
                    ents_q[i].age  <= alloc_age;
                    ents_q[i].avld <= 1'b0;
                end
                if (addr_vld && addr_slot == IDX_W'(i)) begin
                    ents_q[i].avld <= 1'b1;
                    ents_q[i].addr <= addr_wr;
                end
                if (data_vld && data_slot == IDX_W'(i)) begin
                    ents_q[i].data <= data_wr;
                end
            end
        end
    end

    assign ents = ents_q;

    // R2 support: a slot whose address was just written is known next cycle.
    a_r2_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld && !(alloc_vld && alloc_slot == addr_slot)) |=> ents_q[$past(addr_slot)].avld);

endmodule

// File: rtl/stlf_match.sv
// Youngest-match search over one cluster's stores. Only address-known
// entries take part; with lim_en set, only entries older than lim_age.
module stlf_match
    import stlf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  st_entry_t [DEPTH-1:0] ents,
    input  logic [ADDR_W-1:0]     q_addr,
    input  logic                  lim_en,
    input  logic [AGE_W-1:0]      lim_age,
    output logic                  hit,
    output logic [DATA_W-1:0]     hit_data
);

    logic [AGE_W-1:0] best_age;

    // Priority by age: keep the largest qualifying age seen so far.
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ents[i].vld && ents[i].avld && ents[i].addr == q_addr &&
                (!lim_en || ents[i].age < lim_age) &&
                (!hit || ents[i].age > best_age)) begin
                hit      = 1'b1;
                best_age = ents[i].age;
                hit_data = ents[i].data;
            end
        end
    end

endmodule

// File: rtl/stlf_load_ctrl.sv
// Load sequencer for one cluster: accepts one load, holds it while any
// earlier store address is unknown, forwards locally, and (younger
// cluster only) sends one lookup to the older cluster on a local miss.
module stlf_load_ctrl
    import stlf_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter bit HAS_OLDER = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  st_entry_t [DEPTH-1:0] ents,
    input  logic                  req_vld,
    input  logic [AGE_W-1:0]      req_age,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  req_rdy,
    input  logic                  ext_unk,
    output logic                  lkp_vld,
    output logic [ADDR_W-1:0]     lkp_addr,
    input  logic                  x_rsp_vld,
    input  logic                  x_rsp_hit,
    input  logic [DATA_W-1:0]     x_rsp_data,
    output logic                  rsp_vld,
    output logic [1:0]            rsp_src,
    output logic [DATA_W-1:0]     rsp_data
);

    typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_XWAIT} ld_state_t;

    ld_state_t         st_q;
    logic [AGE_W-1:0]  cur_age;
    logic [ADDR_W-1:0] cur_addr;
    logic              loc_hit;
    logic [DATA_W-1:0] loc_data;
    logic              loc_unk;
    logic              held;

    stlf_match #(.DEPTH(DEPTH)) i_match (
        .ents     (ents),
        .q_addr   (cur_addr),
        .lim_en   (1'b1),
        .lim_age  (cur_age),
        .hit      (loc_hit),
        .hit_data (loc_data)
    );

    // Scan for earlier local stores whose address is still unknown.
    always_comb begin
        loc_unk = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ents[i].vld && !ents[i].avld && ents[i].age < cur_age)
                loc_unk = 1'b1;
        end
    end

    assign held    = loc_unk || ext_unk;
    assign req_rdy = (st_q == ST_IDLE);

    // Load sequencing: accept, check each cycle, respond or look up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_age  <= '0;
            cur_addr <= '0;
            lkp_vld  <= 1'b0;
            lkp_addr <= '0;
            rsp_vld  <= 1'b0;
            rsp_src  <= SRC_LOCAL;
            rsp_data <= '0;
        end else begin
            rsp_vld <= 1'b0;
            lkp_vld <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_vld) begin
                        cur_age  <= req_age;
                        cur_addr <= req_addr;
                        st_q     <= ST_CHK;
                    end
                end
                ST_CHK: begin
                    if (!held) begin
                        if (loc_hit) begin
                            rsp_vld  <= 1'b1;
                            rsp_src  <= SRC_LOCAL;
                            rsp_data <= loc_data;
                            st_q     <= ST_IDLE;
                        end else if (HAS_OLDER) begin
                            lkp_vld  <= 1'b1;
                            lkp_addr <= cur_addr;
                            st_q     <= ST_XWAIT;
                        end else begin
                            rsp_vld  <= 1'b1;
                            rsp_src  <= SRC_MEMORY;
                            rsp_data <= '0;
                            st_q     <= ST_IDLE;
                        end
                    end
                end
                ST_XWAIT: begin
                    if (x_rsp_vld) begin
                        rsp_vld  <= 1'b1;
                        rsp_src  <= x_rsp_hit ? SRC_REMOTE : SRC_MEMORY;
                        rsp_data <= x_rsp_hit ? x_rsp_data : '0;
                        st_q     <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R10: an accepted load makes the port busy on the next cycle.
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_rdy) |=> !req_rdy);

    // R3: no response follows a cycle in which the load was held.
    a_r3_hold_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHK && held) |=> !rsp_vld);

    // R5: an unblocked local hit responds without any lookup.
    a_r5_hit_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHK && !held && loc_hit) |=> (rsp_vld && !lkp_vld));

    // R10: a lookup is a single-cycle pulse, never back to back.
    a_r10_single_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_vld |=> !lkp_vld);

    // R7: the older cluster answers in the cycle after a lookup.
    a_r7_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_vld |=> x_rsp_vld);

endmodule

// File: rtl/stlf_xc_older.sv
// Older-cluster side of the stitch: summarises unknown store addresses
// into one flag and answers lookups one cycle later, using only stores
// whose addresses are resolved.
module stlf_xc_older
    import stlf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  st_entry_t [DEPTH-1:0] ents,
    input  logic                  lkp_vld,
    input  logic [ADDR_W-1:0]     lkp_addr,
    output logic                  unknown,
    output logic                  ans_vld,
    output logic                  ans_hit,
    output logic [DATA_W-1:0]     ans_data
);

    logic              m_hit;
    logic [DATA_W-1:0] m_data;

    stlf_match #(.DEPTH(DEPTH)) i_match (
        .ents     (ents),
        .q_addr   (lkp_addr),
        .lim_en   (1'b0),
        .lim_age  ('0),
        .hit      (m_hit),
        .hit_data (m_data)
    );

    // Summary flag: any valid store without a known address.
    always_comb begin
        unknown = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ents[i].vld && !ents[i].avld) unknown = 1'b1;
        end
    end

    // Lookup answer register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ans_vld  <= 1'b0;
            ans_hit  <= 1'b0;
            ans_data <= '0;
        end else begin
            ans_vld  <= lkp_vld;
            ans_hit  <= lkp_vld && m_hit;
            ans_data <= (lkp_vld && m_hit) ? m_data : '0;
        end
    end

    // R4: a lookup is never raised while the older cluster has unknowns.
    a_r4_no_lookup_when_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_vld |-> !$past(unknown));

endmodule

// File: rtl/stitched_stlf.sv
// Top: two cluster store buffers stitched into one forwarding buffer.
// Cluster 0 is older, cluster 1 younger; every store in cluster 0 is
// program-earlier than every load in cluster 1.
module stitched_stlf
    import stlf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  st_alloc_vld,
    input  logic [1:0][IDX_W-1:0]       st_alloc_slot,
    input  logic [1:0][AGE_W-1:0]       st_alloc_age,
    input  logic [1:0]                  st_addr_vld,
    input  logic [1:0][IDX_W-1:0]       st_addr_slot,
    input  logic [1:0][ADDR_W-1:0]      st_addr,
    input  logic [1:0]                  st_data_vld,
    input  logic [1:0][IDX_W-1:0]       st_data_slot,
    input  logic [1:0][DATA_W-1:0]      st_data,
    input  logic [1:0]                  ld_req_vld,
    input  logic [1:0][AGE_W-1:0]       ld_req_age,
    input  logic [1:0][ADDR_W-1:0]      ld_req_addr,
    output logic [1:0]                  ld_req_rdy,
    output logic [1:0]                  ld_rsp_vld,
    output logic [1:0][1:0]             ld_rsp_src,
    output logic [1:0][DATA_W-1:0]      ld_rsp_data,
    output logic                        xc_unknown,
    output logic                        xc_lookup_vld,
    output logic [ADDR_W-1:0]           xc_lookup_addr,
    output logic                        xc_answer_vld,
    output logic                        xc_answer_hit
);

    st_entry_t [1:0][DEPTH-1:0] ents_c;
    logic      [1:0]            lkp_vld_c;
    logic      [1:0][ADDR_W-1:0] lkp_addr_c;
    logic      [DATA_W-1:0]     ans_data;

    for (genvar c = 0; c < 2; c++) begin : g_cluster
        localparam bit YOUNG = (c == 1);

        stlf_store_array #(.DEPTH(DEPTH)) i_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_vld  (st_alloc_vld[c]),
            .alloc_slot (st_alloc_slot[c]),
            .alloc_age  (st_alloc_age[c]),
            .addr_vld   (st_addr_vld[c]),
            .addr_slot  (st_addr_slot[c]),
            .addr_wr    (st_addr[c]),
            .data_vld   (st_data_vld[c]),
            .data_slot  (st_data_slot[c]),
            .data_wr    (st_data[c]),
            .ents       (ents_c[c])
        );

        stlf_load_ctrl #(.DEPTH(DEPTH), .HAS_OLDER(YOUNG)) i_load (
            .clk        (clk),
            .rst_n      (rst_n),
            .ents       (ents_c[c]),
            .req_vld    (ld_req_vld[c]),
            .req_age    (ld_req_age[c]),
            .req_addr   (ld_req_addr[c]),
            .req_rdy    (ld_req_rdy[c]),
            .ext_unk    (YOUNG ? xc_unknown : 1'b0),
            .lkp_vld    (lkp_vld_c[c]),
            .lkp_addr   (lkp_addr_c[c]),
            .x_rsp_vld  (YOUNG ? xc_answer_vld : 1'b0),
            .x_rsp_hit  (YOUNG ? xc_answer_hit : 1'b0),
            .x_rsp_data (YOUNG ? ans_data : '0),
            .rsp_vld    (ld_rsp_vld[c]),
            .rsp_src    (ld_rsp_src[c]),
            .rsp_data   (ld_rsp_data[c])
        );
    end

    assign xc_lookup_vld  = lkp_vld_c[1];
    assign xc_lookup_addr = lkp_addr_c[1];

    stlf_xc_older #(.DEPTH(DEPTH)) i_xc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ents     (ents_c[0]),
        .lkp_vld  (xc_lookup_vld),
        .lkp_addr (xc_lookup_addr),
        .unknown  (xc_unknown),
        .ans_vld  (xc_answer_vld),
        .ans_hit  (xc_answer_hit),
        .ans_data (ans_data)
    );

    // R9: the older cluster's sequencer never raises a lookup.
    a_r9_older_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_vld_c[0] && lkp_addr_c[0] == '0);

endmodule

// File: tb/test_stitched_stlf.sv
`timescale 1ns/1ps
module test_stitched_stlf;
    localparam int DEPTH = 8;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]             st_alloc_vld;
    logic [1:0][IDX_W-1:0]  st_alloc_slot;
    logic [1:0][7:0]        st_alloc_age;
    logic [1:0]             st_addr_vld;
    logic [1:0][IDX_W-1:0]  st_addr_slot;
    logic [1:0][29:0]       st_addr;
    logic [1:0]             st_data_vld;
    logic [1:0][IDX_W-1:0]  st_data_slot;
    logic [1:0][31:0]       st_data;
    logic [1:0]             ld_req_vld;
    logic [1:0][7:0]        ld_req_age;
    logic [1:0][29:0]       ld_req_addr;
    logic [1:0]             ld_req_rdy;
    logic [1:0]             ld_rsp_vld;
    logic [1:0][1:0]        ld_rsp_src;
    logic [1:0][31:0]       ld_rsp_data;
    logic                   xc_unknown;
    logic                   xc_lookup_vld;
    logic [29:0]            xc_lookup_addr;
    logic                   xc_answer_vld;
    logic                   xc_answer_hit;

    int n_chk = 0;
    int n_fail = 0;
    int lkp_cnt = 0;
    logic [29:0] lkp_last = '0;

    always #4 clk = ~clk;

    stitched_stlf #(.DEPTH(DEPTH)) i_stitched_stlf (.*);

    // Count lookups leaving the younger cluster.
    always @(negedge clk) begin
        if (rst_n && xc_lookup_vld) begin
            lkp_cnt  = lkp_cnt + 1;
            lkp_last = xc_lookup_addr;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        st_alloc_vld = '0; st_alloc_slot = '0; st_alloc_age = '0;
        st_addr_vld = '0;  st_addr_slot = '0;  st_addr = '0;
        st_data_vld = '0;  st_data_slot = '0;  st_data = '0;
        ld_req_vld = '0;   ld_req_age = '0;    ld_req_addr = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_store(int c, logic [2:0] slot, logic [7:0] age,
                             logic [29:0] a, logic [31:0] d, bit known);
        st_alloc_vld[c] = 1'b1; st_alloc_slot[c] = slot; st_alloc_age[c] = age;
        st_data_vld[c] = 1'b1;  st_data_slot[c] = slot;  st_data[c] = d;
        st_addr_vld[c] = known; st_addr_slot[c] = slot;  st_addr[c] = a;
        @(negedge clk);
        st_alloc_vld[c] = 1'b0; st_data_vld[c] = 1'b0; st_addr_vld[c] = 1'b0;
    endtask

    task automatic resolve(int c, logic [2:0] slot, logic [29:0] a);
        st_addr_vld[c] = 1'b1; st_addr_slot[c] = slot; st_addr[c] = a;
        @(negedge clk);
        st_addr_vld[c] = 1'b0;
    endtask

    task automatic issue(int c, logic [7:0] age, logic [29:0] a);
        ld_req_vld[c] = 1'b1; ld_req_age[c] = age; ld_req_addr[c] = a;
        @(negedge clk);
        ld_req_vld[c] = 1'b0;
    endtask

    task automatic wait_rsp(int c, output int lat, output logic [1:0] src,
                            output logic [31:0] d);
        lat = 0;
        while (!ld_rsp_vld[c] && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        src = ld_rsp_src[c];
        d   = ld_rsp_data[c];
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ready", 64'(ld_req_rdy), 64'h3);
        chk("R1 rsp_vld", 64'(ld_rsp_vld), 64'h0);
        chk("R1 unknown", 64'(xc_unknown), 64'h0);
        chk("R1 lookup", 64'(xc_lookup_vld), 64'h0);
    endtask

    task automatic t_unknown_flag();
        do_reset();
        put_store(1, 3'd0, 8'd30, 30'h0, 32'h0, 1'b0);
        chk("R2 younger unknown no flag", 64'(xc_unknown), 64'h0);
        put_store(0, 3'd2, 8'd3, 30'h0, 32'h0, 1'b0);
        chk("R2 older unknown flag", 64'(xc_unknown), 64'h1);
        resolve(0, 3'd2, 30'h50);
        chk("R2 flag clears", 64'(xc_unknown), 64'h0);
    endtask

    task automatic t_local_hit();
        int lat; logic [1:0] src; logic [31:0] d; int l0;
        do_reset();
        put_store(1, 3'd0, 8'd10, 30'h100, 32'hA1, 1'b1);
        put_store(1, 3'd1, 8'd12, 30'h100, 32'hA2, 1'b1);
        put_store(1, 3'd2, 8'd20, 30'h100, 32'hA3, 1'b1);
        put_store(1, 3'd3, 8'd11, 30'h104, 32'hB1, 1'b1);
        put_store(1, 3'd4, 8'd25, 30'h0, 32'h0, 1'b0);
        l0 = lkp_cnt;
        issue(1, 8'd15, 30'h100);
        chk("R10 busy after accept", 64'(ld_req_rdy[1]), 64'h0);
        wait_rsp(1, lat, src, d);
        chk("R5 local latency", 64'(lat), 64'd1);
        chk("R5 local src", 64'(src), 64'd0);
        chk("R5 R6 youngest earlier data", 64'(d), 64'hA2);
        chk("R5 no lookup", 64'(lkp_cnt - l0), 64'd0);
    endtask

    task automatic t_remote();
        int lat; logic [1:0] src; logic [31:0] d; int l0;
        do_reset();
        put_store(0, 3'd0, 8'd1, 30'h200, 32'h5, 1'b1);
        put_store(0, 3'd1, 8'd3, 30'h200, 32'h7, 1'b1);
        put_store(0, 3'd2, 8'd2, 30'h200, 32'h9, 1'b1);
        put_store(0, 3'd3, 8'd4, 30'h201, 32'h33, 1'b1);
        put_store(1, 3'd0, 8'd10, 30'h201, 32'h44, 1'b1);
        l0 = lkp_cnt;
        issue(1, 8'd15, 30'h200);
        wait_rsp(1, lat, src, d);
        chk("R7 remote latency", 64'(lat), 64'd3);
        chk("R7 remote src", 64'(src), 64'd1);
        chk("R7 R11 remote youngest data", 64'(d), 64'h7);
        chk("R7 one lookup", 64'(lkp_cnt - l0), 64'd1);
        chk("R7 lookup addr", 64'(lkp_last), 64'h200);
        l0 = lkp_cnt;
        issue(1, 8'd16, 30'h300);
        wait_rsp(1, lat, src, d);
        chk("R8 memory latency", 64'(lat), 64'd3);
        chk("R8 memory src", 64'(src), 64'd2);
        chk("R8 memory data", 64'(d), 64'h0);
        chk("R8 one lookup", 64'(lkp_cnt - l0), 64'd1);
    endtask

    task automatic t_block_local();
        int seen = 0; int extra = 0;
        do_reset();
        put_store(1, 3'd0, 8'd10, 30'h0, 32'hC0, 1'b0);
        issue(1, 8'd12, 30'h400);
        for (int k = 0; k < 5; k++) begin
            if (k == 2) ld_req_vld[1] = 1'b1;
            ld_req_addr[1] = 30'h999;
            if (ld_rsp_vld[1]) seen++;
            @(negedge clk);
            ld_req_vld[1] = 1'b0;
        end
        chk("R3 held no rsp", 64'(seen), 64'd0);
        chk("R10 still busy", 64'(ld_req_rdy[1]), 64'h0);
        resolve(1, 3'd0, 30'h400);
        chk("R3 not yet", 64'(ld_rsp_vld[1]), 64'h0);
        @(negedge clk);
        chk("R3 release cycle", 64'(ld_rsp_vld[1]), 64'h1);
        chk("R3 src", 64'(ld_rsp_src[1]), 64'd0);
        chk("R3 data", 64'(ld_rsp_data[1]), 64'hC0);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (ld_rsp_vld[1]) extra++;
        end
        chk("R10 busy request ignored", 64'(extra), 64'd0);
    endtask

    task automatic t_block_older();
        int lat; logic [1:0] src; logic [31:0] d; int l0; int seen = 0;
        do_reset();
        put_store(0, 3'd0, 8'd2, 30'h0, 32'hD0, 1'b0);
        put_store(1, 3'd1, 8'd20, 30'h0, 32'h0, 1'b0);
        l0 = lkp_cnt;
        issue(1, 8'd12, 30'h500);
        for (int k = 0; k < 5; k++) begin
            if (ld_rsp_vld[1]) seen++;
            @(negedge clk);
        end
        chk("R4 held no rsp", 64'(seen), 64'd0);
        chk("R4 held no lookup", 64'(lkp_cnt - l0), 64'd0);
        resolve(0, 3'd0, 30'h500);
        chk("R2 flag after resolve", 64'(xc_unknown), 64'h0);
        wait_rsp(1, lat, src, d);
        chk("R4 R6 release latency", 64'(lat), 64'd3);
        chk("R4 remote src", 64'(src), 64'd1);
        chk("R4 remote data", 64'(d), 64'hD0);
    endtask

    task automatic t_older_load();
        int lat; logic [1:0] src; logic [31:0] d; int l0;
        do_reset();
        put_store(0, 3'd0, 8'd5, 30'h600, 32'h61, 1'b1);
        put_store(0, 3'd1, 8'd8, 30'h0, 32'h81, 1'b0);
        l0 = lkp_cnt;
        issue(0, 8'd7, 30'h600);
        wait_rsp(0, lat, src, d);
        chk("R6 R9 later unknown ignored latency", 64'(lat), 64'd1);
        chk("R9 local data", 64'(d), 64'h61);
        issue(0, 8'd10, 30'h700);
        repeat (3) @(negedge clk);
        chk("R3 older held", 64'(ld_rsp_vld[0]), 64'h0);
        resolve(0, 3'd1, 30'h700);
        @(negedge clk);
        chk("R3 older release", 64'(ld_rsp_vld[0]), 64'h1);
        chk("R3 older data", 64'(ld_rsp_data[0]), 64'h81);
        @(negedge clk);
        issue(0, 8'd10, 30'h800);
        wait_rsp(0, lat, src, d);
        chk("R9 memory latency", 64'(lat), 64'd1);
        chk("R9 memory src", 64'(src), 64'd2);
        chk("R9 no lookups", 64'(lkp_cnt - l0), 64'd0);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        t_reset();
        t_unknown_flag();
        t_local_hit();
        t_remote();
        t_block_local();
        t_block_older();
        t_older_load();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule